// File: doc/BRIEF.md
# Trigger DMA Request Generator

This block turns the completion of a trigger group's conversion chain into a DMA request line. There is one request line and one acknowledge line for each trigger group. A group raises its request only when its enable bit is set at the moment its completion indication rises. Two hardware-only completion sources are also connected. They never produce a request and never set a status bit.

A single mode input selects how a raised request is withdrawn. In latched mode, the request stays up until the acknowledge has been seen and the group's completion level has dropped, in either order. In pulsed mode, the acknowledge alone withdraws it. Software reaches the block through one 32-bit control word. The enable bits sit in its low bits. A sticky status bit for each group sits at bit 16 plus the group index. Writing 1 to a status bit clears it and writing 0 leaves it alone, so the enables can be rewritten without losing status.

Top module: `trig_dma_req_gen`

## Requirements
- R1: After reset all request lines are 0, and the control word reads 0 (all enables off, all status bits clear).
- R2: A control write loads enable bit g from write-data bit g, for g = 0..NUM_GROUPS-1. The read value shows those enables in the same bits from the cycle after the write.
- R3: A rising edge on a group's completion input while that group's enable is 1 sets its request line and its status bit (control-word bit 16+g) in the next cycle. The same edge with the enable at 0 sets neither.
- R4: In latched mode (mode input 0), a request is withdrawn one cycle after both conditions hold: the acknowledge has been seen since the request rose, and the completion input is low. The two may arrive in either order. While the completion input stays high, the request stays up.
- R5: In pulsed mode (mode input 1), an acknowledge withdraws the request in the next cycle even while the completion input is still high. A completion level that stays high does not raise the request again.
- R6: If an acknowledge and a new completion edge reach a group in the same cycle, its request stays asserted.
- R7: When a group's enable is 0, its request line is 0 in the following cycle.
- R8: On a control write, each status bit 16+g written with 1 is cleared. Each status bit written with 0 keeps its value.
- R9: If a status bit is set by a completion and cleared by a write in the same cycle, the bit ends up set.
- R10: The hardware-only completion inputs never change any request line or status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulsed_mode_i | input | 1 | Request-withdraw style: 0 latched, 1 pulsed |
| chain_done_i | input | NUM_GROUPS | Per-group completion level; a rising edge is a completion |
| hw_only_done_i | input | NUM_HW_ONLY | Completions of the hardware-only sources (no DMA) |
| dma_ack_i | input | NUM_GROUPS | Per-group DMA acknowledge |
| ctl_wr_i | input | 1 | Control-word write strobe |
| ctl_wdata_i | input | 32 | Control-word write data |
| ctl_rdata_o | output | 32 | Control word: enables in low bits, status at bit 16+g |
| dma_req_o | output | NUM_GROUPS | Per-group DMA request |

## Verification
Several properties are checked on every cycle inside the lanes. A disabled group drops its request. A completion edge with the enable set raises the request. In pulsed mode an acknowledge withdraws the request, while in latched mode the request holds as long as the completion level is high. A collision keeps the request up. In the register, a write loads the enables, and a status bit written with 0 survives the write. Some behaviour can only be shown by the directed scenarios: the two orderings of acknowledge and release in latched mode, that a completion level held high in pulsed mode does not raise the request again, set-over-clear priority on a status bit, and that the hardware-only sources leave the request lines and the control word unchanged.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    localparam int CTL_W    = 32;
    localparam int STAT_LSB = 16;

    typedef struct packed {
        logic req;
        logic ack_seen;
        logic done_prev;
    } lane_state_t;

endpackage

// File: rtl/dmareq_lane.sv
module dmareq_lane
    import dmareq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic pulsed_i,
    input  logic done_i,
    input  logic ack_i,
    output logic req_o,
    output logic event_o
);

    lane_state_t s_d, s_q;
    logic        rise;

    always_comb begin
        s_d           = s_q;
        rise          = done_i & ~s_q.done_prev;
        s_d.done_prev = done_i;
        if (!en_i) begin
            s_d.req      = 1'b0;
            s_d.ack_seen = 1'b0;
        end else if (rise) begin
            s_d.req      = 1'b1;
            s_d.ack_seen = 1'b0;
        end else if (s_q.req) begin
            if (pulsed_i) begin
                if (ack_i) begin
                    s_d.req = 1'b0;
                end
            end else if ((ack_i || s_q.ack_seen) && !done_i) begin
                s_d.req      = 1'b0;
                s_d.ack_seen = 1'b0;
            end else if (ack_i) begin
                s_d.ack_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o   = s_q.req;
    assign event_o = rise & en_i;

    a_r7_disable_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !req_o);

    a_r3_edge_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && done_i && !s_q.done_prev) |=> req_o);

    a_r5_pulsed_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && pulsed_i && req_o && ack_i && !(done_i && !s_q.done_prev)) |=> !req_o);

    a_r4_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !pulsed_i && req_o && done_i) |=> req_o);

    a_r6_collision_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && req_o && ack_i && done_i && !s_q.done_prev) |=> req_o);

endmodule

// File: rtl/dmareq_ctl.sv
module dmareq_ctl
    import dmareq_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [CTL_W-1:0]      wdata_i,
    input  logic [NUM_GROUPS-1:0] set_i,
    output logic [NUM_GROUPS-1:0] en_o,
    output logic [CTL_W-1:0]      rdata_o
);

    localparam logic [CTL_W-1:0] EN_MASK   = CTL_W'((64'd1 << NUM_GROUPS) - 1);
    localparam logic [CTL_W-1:0] STAT_MASK = EN_MASK << STAT_LSB;

    typedef struct packed {
        logic [NUM_GROUPS-1:0] en;
        logic [NUM_GROUPS-1:0] stat;
    } ctl_state_t;

    ctl_state_t c_d, c_q;
    logic [NUM_GROUPS-1:0] w1c;
    logic unused_wdata;

    always_comb begin
        c_d = c_q;
        w1c = wr_i ? wdata_i[STAT_LSB +: NUM_GROUPS] : '0;
        if (wr_i) begin
            c_d.en = wdata_i[NUM_GROUPS-1:0];
        end
        c_d.stat = (c_q.stat & ~w1c) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign en_o         = c_q.en;
    assign rdata_o      = (CTL_W'(c_q.en) & EN_MASK) | ((CTL_W'(c_q.stat) << STAT_LSB) & STAT_MASK);
    assign unused_wdata = ^(wdata_i & ~(EN_MASK | STAT_MASK));

    a_r2_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (en_o == $past(wdata_i[NUM_GROUPS-1:0])));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_stat_chk
        a_r8_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && !wdata_i[STAT_LSB+g] && c_q.stat[g]) |=> c_q.stat[g]);
    end

endmodule

// File: rtl/trig_dma_req_gen.sv
module trig_dma_req_gen
    import dmareq_pkg::*;
#(
    parameter int NUM_GROUPS  = 8,
    parameter int NUM_HW_ONLY = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   pulsed_mode_i,
    input  logic [NUM_GROUPS-1:0]  chain_done_i,
    input  logic [NUM_HW_ONLY-1:0] hw_only_done_i,
    input  logic [NUM_GROUPS-1:0]  dma_ack_i,
    input  logic                   ctl_wr_i,
    input  logic [CTL_W-1:0]       ctl_wdata_i,
    output logic [CTL_W-1:0]       ctl_rdata_o,
    output logic [NUM_GROUPS-1:0]  dma_req_o
);

    logic [NUM_GROUPS-1:0] en;
    logic [NUM_GROUPS-1:0] evt;
    logic                  unused_hw_only;

    initial begin
        if (NUM_GROUPS > STAT_LSB) $error("NUM_GROUPS exceeds status field offset");
    end

    dmareq_ctl #(.NUM_GROUPS(NUM_GROUPS)) u_ctl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (ctl_wr_i),
        .wdata_i (ctl_wdata_i),
        .set_i   (evt),
        .en_o    (en),
        .rdata_o (ctl_rdata_o)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
        dmareq_lane u_lane (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (en[g]),
            .pulsed_i (pulsed_mode_i),
            .done_i   (chain_done_i[g]),
            .ack_i    (dma_ack_i[g]),
            .req_o    (dma_req_o[g]),
            .event_o  (evt[g])
        );
    end

    // R10: hardware-only sources have no request path
    assign unused_hw_only = ^hw_only_done_i;

endmodule

// File: tb/trig_dma_req_gen_tb.sv
module trig_dma_req_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulsed = 1'b0;
    logic [7:0]  done = '0;
    logic [1:0]  hw_only = '0;
    logic [7:0]  ack = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trig_dma_req_gen u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .pulsed_mode_i  (pulsed),
        .chain_done_i   (done),
        .hw_only_done_i (hw_only),
        .dma_ack_i      (ack),
        .ctl_wr_i       (wr),
        .ctl_wdata_i    (wdata),
        .ctl_rdata_o    (rdata),
        .dma_req_o      (req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [31:0] d);
        wr = 1'b1;
        wdata = d;
        step();
        wr = 1'b0;
        wdata = '0;
    endtask

    task automatic t_reset();
        chk(32'(req), 32'h0, "R1 requests after reset");
        chk(rdata, 32'h0, "R1 control word after reset");
    endtask

    task automatic t_enables();
        write_ctl(32'h0000_005A);
        chk(rdata, 32'h0000_005A, "R2 enable readback");
        write_ctl(32'h0000_00FD);
        chk(rdata, 32'h0000_00FD, "R2 enable rewrite");
    endtask

    task automatic t_disabled_group();
        done[1] = 1'b1;
        step();
        chk(32'(req[1]), 32'h0, "R3 no request without enable");
        chk(32'(rdata[17]), 32'h0, "R3 no status without enable");
        done[1] = 1'b0;
        step();
    endtask

    task automatic t_latched();
        pulsed = 1'b0;
        done[0] = 1'b1;
        step();
        chk(32'(req[0]), 32'h1, "R3 request raised");
        chk(32'(rdata[16]), 32'h1, "R3 status raised");
        ack[0] = 1'b1;
        step();
        ack[0] = 1'b0;
        chk(32'(req[0]), 32'h1, "R4 ack with source high holds");
        step();
        chk(32'(req[0]), 32'h1, "R4 still held");
        done[0] = 1'b0;
        step();
        chk(32'(req[0]), 32'h0, "R4 release after ack clears");
        done[2] = 1'b1;
        step();
        done[2] = 1'b0;
        step();
        chk(32'(req[2]), 32'h1, "R4 release before ack holds");
        ack[2] = 1'b1;
        step();
        ack[2] = 1'b0;
        chk(32'(req[2]), 32'h0, "R4 ack after release clears");
    endtask

    task automatic t_pulsed();
        pulsed = 1'b1;
        done[3] = 1'b1;
        step();
        chk(32'(req[3]), 32'h1, "R5 request raised");
        ack[3] = 1'b1;
        step();
        ack[3] = 1'b0;
        chk(32'(req[3]), 32'h0, "R5 ack alone clears");
        step();
        chk(32'(req[3]), 32'h0, "R5 held level does not re-raise");
        done[3] = 1'b0;
        step();
    endtask

    task automatic t_collision();
        done[4] = 1'b1;
        step();
        done[4] = 1'b0;
        step();
        chk(32'(req[4]), 32'h1, "R6 request pending");
        done[4] = 1'b1;
        ack[4] = 1'b1;
        step();
        ack[4] = 1'b0;
        chk(32'(req[4]), 32'h1, "R6 ack with new completion keeps");
        ack[4] = 1'b1;
        step();
        ack[4] = 1'b0;
        chk(32'(req[4]), 32'h0, "R6 later ack clears");
        done[4] = 1'b0;
        step();
    endtask

    task automatic t_disable();
        done[5] = 1'b1;
        step();
        done[5] = 1'b0;
        chk(32'(req[5]), 32'h1, "R7 request pending");
        write_ctl(32'h0000_00DD);
        step();
        chk(32'(req[5]), 32'h0, "R7 disable drops request");
        chk(rdata, 32'h003D_00DD, "R8 zero write keeps status");
    endtask

    task automatic t_w1c();
        write_ctl(32'h0001_00DD);
        chk(rdata, 32'h003C_00DD, "R8 write one clears only bit 16");
    endtask

    task automatic t_set_wins();
        done[6] = 1'b1;
        write_ctl(32'h0040_00DD);
        chk(rdata, 32'h007C_00DD, "R9 set wins over clear");
        chk(32'(req[6]), 32'h1, "R9 request raised");
        done[6] = 1'b0;
        step();
    endtask

    task automatic t_hw_only();
        hw_only = 2'b11;
        step();
        hw_only = 2'b00;
        step();
        chk(32'(req), 32'h0000_0040, "R10 requests unchanged");
        chk(rdata, 32'h007C_00DD, "R10 control word unchanged");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enables();
        t_disabled_group();
        t_latched();
        t_pulsed();
        t_collision();
        t_disable();
        t_w1c();
        t_set_wins();
        t_hw_only();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule